// File: doc/BRIEF.md
# Reservation-Based Atomic Memory Unit

This unit sits in front of a single word-wide synchronous memory port and serves atomic requests from several hardware threads, one at a time. A request carries an operation code, a byte address, a write operand and a thread number. The unit supports three kinds of request. A load-reserved returns a word and marks that word as reserved for the requesting thread. A store-conditional writes only while that reservation still holds, and it reports success or failure. A fetch-and-op reads a word, combines it with the operand, writes the result back and returns the original word.

Each thread holds one reservation. Other agents that write the same memory report their writes on a snoop port, and any such write to a reserved word cancels the reservation on that word. Writes that the unit makes for one thread cancel matching reservations held by the other threads. A request that is misaligned, or that uses an operation code with no meaning, is refused with a fault cause and makes no memory access.

Top module: `atomic_mem_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `reqReady` is 1, `rspValid` is 0 and `memEn` is 0.
- R2: A load-reserved (op 0) returns the addressed word in `rspData` with `rspErr` 0, and it records a reservation on that word for `reqTid`.
- R3: A store-conditional (op 1) whose thread holds a reservation on the same word writes `reqData` to memory and returns 0.
- R4: A store-conditional whose thread has no reservation, or has one on another word, returns 1 and leaves memory unchanged.
- R5: Every store-conditional clears its own thread's reservation, so a second store-conditional with no load-reserved in between fails.
- R6: A snoop write (`snoopValid` with `snoopAddr` equal to the reserved word address) cancels the reservation. A write the unit makes for another thread to the reserved word also cancels it. A write the unit makes for the same thread does not.
- R7: Reservations belong to threads. A load-reserved by one thread neither grants a reservation to another thread nor disturbs another thread's reservation on a different word.
- R8: Fetch-and-op codes are 2 swap, 3 add (modulo 2^DATA_W), 4 and, 5 or and 6 xor. Each one returns the original word and writes f(old, operand).
- R9: Codes 7 and 9 write the signed maximum and signed minimum (two's complement), and codes 8 and 10 write the unsigned maximum and unsigned minimum of the old word and the operand.
- R10: A request whose byte address has nonzero low log2(DATA_W/8) bits returns `rspErr` 1, `rspCause` 6 and `rspData` 0, and makes no memory access.
- R11: An aligned request with op 11 to 15 returns `rspErr` 1 and `rspCause` 7, and makes no memory access.
- R12: A request is accepted on a clock edge where both `reqValid` and `reqReady` are 1. `reqReady` then stays 0 until the response. `rspValid` is a one-cycle pulse, and `reqReady` is 1 again in the cycle after it. A fetch-and-op's memory read and write happen with no other request granted between them.
- R13: `rspValid` rises in cycle 1 after the accepting edge for a refused request, in cycle 2 for a store-conditional, in cycle 3 for a load-reserved and in cycle 4 for a fetch-and-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle and able to take a request |
| reqOp | input | 4 | Operation code |
| reqAddr | input | ADDR_W | Byte address |
| reqData | input | DATA_W | Store or fetch-and-op operand |
| reqTid | input | TID_W | Requesting thread number |
| rspValid | output | 1 | One-cycle response pulse |
| rspData | output | DATA_W | Old word, or 0/1 store-conditional result |
| rspErr | output | 1 | Request refused |
| rspCause | output | 4 | Fault cause: 6 misaligned, 7 access fault |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W-log2(DATA_W/8) | Word address |
| memWData | output | DATA_W | Write data |
| memRData | input | DATA_W | Read data, valid the cycle after a read |
| snoopValid | input | 1 | Another agent writes memory this cycle |
| snoopAddr | input | ADDR_W-log2(DATA_W/8) | Word address of that write |

## Verification
The bench builds the unit with 16-bit words, a 6-bit byte address (32 words) and three threads. At these widths twelve signed and unsigned corner values, crossed with each other under all nine fetch-and-op codes, cover every min/max sign boundary and carry case at a modest run length. With three threads, the bench can set up reservation races between threads and with snoop writes. With a one-bit byte offset, the bench can drive both aligned and misaligned addresses.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [3:0] {
    OP_LR   = 4'd0,
    OP_SC   = 4'd1,
    OP_SWAP = 4'd2,
    OP_ADD  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_MAX  = 4'd7,
    OP_MAXU = 4'd8,
    OP_MIN  = 4'd9,
    OP_MINU = 4'd10
  } amoOp_e;

  typedef enum logic [2:0] {
    CLS_LR,
    CLS_SC,
    CLS_RMW,
    CLS_MISALIGN,
    CLS_BADOP
  } reqClass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DATA,
    ST_WRITE,
    ST_RESP
  } state_e;

  typedef struct packed {
    logic latchReq;
    logic memRead;
    logic latchOld;
    logic setRes;
    logic rmwWrite;
    logic scEval;
  } strobe_t;

  localparam logic [3:0] CAUSE_ST_MISALIGN = 4'd6;
  localparam logic [3:0] CAUSE_ST_ACCESS   = 4'd7;

endpackage

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  reqClass_e inClass,
  output logic      reqReady,
  output logic      rspValid,
  output strobe_t   strobe
);

  state_e    state, stateNext;
  reqClass_e cls;
  logic      accept;

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe          = '0;
    strobe.latchReq = accept;
    strobe.memRead  = (state == ST_ISSUE);
    strobe.latchOld = (state == ST_DATA);
    strobe.setRes   = (state == ST_DATA) && (cls == CLS_LR);
    strobe.rmwWrite = (state == ST_WRITE) && (cls == CLS_RMW);
    strobe.scEval   = (state == ST_WRITE) && (cls == CLS_SC);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) begin
        unique case (inClass)
          CLS_LR, CLS_RMW: stateNext = ST_ISSUE;
          CLS_SC:          stateNext = ST_WRITE;
          default:         stateNext = ST_RESP;
        endcase
      end
      ST_ISSUE: stateNext = ST_DATA;
      ST_DATA:  stateNext = (cls == CLS_LR) ? ST_RESP : ST_WRITE;
      ST_WRITE: stateNext = ST_RESP;
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cls   <= CLS_LR;
    end else begin
      state <= stateNext;
      if (accept) cls <= inClass;
    end
  end

endmodule

// File: rtl/amu_datapath.sv
module amu_datapath
  import amu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int THREADS = 4,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int OFF_W   = $clog2(DATA_W / 8),
  localparam int WADDR_W = ADDR_W - OFF_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strobe,
  input  logic [3:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [TID_W-1:0]   reqTid,
  input  logic [DATA_W-1:0]  memRData,
  input  logic               snoopValid,
  input  logic [WADDR_W-1:0] snoopAddr,
  output reqClass_e          inClass,
  output logic               memEn,
  output logic               memWe,
  output logic [WADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]  memWData,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspErr,
  output logic [3:0]         rspCause
);

  logic [3:0]         opQ;
  logic [WADDR_W-1:0] addrQ;
  logic [DATA_W-1:0]  dataQ;
  logic [TID_W-1:0]   tidQ;
  logic [DATA_W-1:0]  oldQ;
  logic [DATA_W-1:0]  aluOut;
  logic [THREADS-1:0] ownOk;
  logic               snoopSame;
  logic               scOk;

  // classify the incoming request
  always_comb begin
    if (reqAddr[OFF_W-1:0] != '0)     inClass = CLS_MISALIGN;
    else if (reqOp == OP_LR)           inClass = CLS_LR;
    else if (reqOp == OP_SC)           inClass = CLS_SC;
    else if (reqOp <= OP_MINU)         inClass = CLS_RMW;
    else                               inClass = CLS_BADOP;
  end

  // read-modify-write combine
  always_comb begin
    unique case (opQ)
      OP_SWAP: aluOut = dataQ;
      OP_ADD:  aluOut = oldQ + dataQ;
      OP_AND:  aluOut = oldQ & dataQ;
      OP_OR:   aluOut = oldQ | dataQ;
      OP_XOR:  aluOut = oldQ ^ dataQ;
      OP_MAX:  aluOut = ($signed(oldQ) > $signed(dataQ)) ? oldQ : dataQ;
      OP_MAXU: aluOut = (oldQ > dataQ) ? oldQ : dataQ;
      OP_MIN:  aluOut = ($signed(oldQ) < $signed(dataQ)) ? oldQ : dataQ;
      OP_MINU: aluOut = (oldQ < dataQ) ? oldQ : dataQ;
      default: aluOut = oldQ;
    endcase
  end

  assign snoopSame = snoopValid && (snoopAddr == addrQ);
  assign scOk      = (|ownOk) && !snoopSame;

  assign memEn    = strobe.memRead | strobe.rmwWrite | (strobe.scEval & scOk);
  assign memWe    = strobe.rmwWrite | (strobe.scEval & scOk);
  assign memAddr  = addrQ;
  assign memWData = strobe.rmwWrite ? aluOut : dataQ;

  // one reservation per thread
  for (genvar t = 0; t < THREADS; t++) begin : g_res
    logic               resValid;
    logic [WADDR_W-1:0] resAddr;
    logic               isOwn;
    logic [WADDR_W-1:0] effAddr;
    logic               snoopKill;
    logic               peerKill;

    assign isOwn     = (tidQ == TID_W'(t));
    assign effAddr   = (strobe.setRes && isOwn) ? addrQ : resAddr;
    assign snoopKill = snoopValid && (snoopAddr == effAddr);
    assign peerKill  = memWe && !isOwn && (addrQ == effAddr);
    assign ownOk[t]  = isOwn && resValid && (resAddr == addrQ);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resValid <= 1'b0;
        resAddr  <= '0;
      end else begin
        if (strobe.setRes && isOwn) begin
          resValid <= 1'b1;
          resAddr  <= addrQ;
        end
        if (strobe.scEval && isOwn) resValid <= 1'b0;
        if (snoopKill || peerKill)  resValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opQ      <= '0;
      addrQ    <= '0;
      dataQ    <= '0;
      tidQ     <= '0;
      oldQ     <= '0;
      rspData  <= '0;
      rspErr   <= 1'b0;
      rspCause <= '0;
    end else begin
      if (strobe.latchReq) begin
        opQ      <= reqOp;
        addrQ    <= reqAddr[ADDR_W-1:OFF_W];
        dataQ    <= reqData;
        tidQ     <= reqTid;
        rspData  <= '0;
        rspErr   <= (inClass == CLS_MISALIGN) || (inClass == CLS_BADOP);
        rspCause <= (inClass == CLS_MISALIGN) ? CAUSE_ST_MISALIGN :
                    (inClass == CLS_BADOP)    ? CAUSE_ST_ACCESS   : 4'd0;
      end
      if (strobe.latchOld) begin
        oldQ    <= memRData;
        rspData <= memRData;
      end
      if (strobe.scEval) rspData <= scOk ? '0 : DATA_W'(1);
    end
  end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int THREADS = 4,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int OFF_W   = $clog2(DATA_W / 8),
  localparam int WADDR_W = ADDR_W - OFF_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [3:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [TID_W-1:0]   reqTid,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspErr,
  output logic [3:0]         rspCause,
  output logic               memEn,
  output logic               memWe,
  output logic [WADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]  memWData,
  input  logic [DATA_W-1:0]  memRData,
  input  logic               snoopValid,
  input  logic [WADDR_W-1:0] snoopAddr
);

  strobe_t   strobe;
  reqClass_e inClass;

  amu_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .inClass  (inClass),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  amu_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .THREADS (THREADS)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqTid     (reqTid),
    .memRData   (memRData),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .inClass    (inClass),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWData   (memWData),
    .rspData    (rspData),
    .rspErr     (rspErr),
    .rspCause   (rspCause)
  );

endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int OFF_W = 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic [3:0]       reqOp,
  input logic [OFF_W-1:0] reqAddrLow,
  input logic             rspValid,
  input logic             rspErr,
  input logic [3:0]       rspCause,
  input logic             memEn,
  input logic             memWe
);

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> (!rspValid && reqReady)); // R12

  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady); // R12

  AST_RESP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (memEn && memWe) |=> rspValid); // R12

  AST_MISALIGN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqAddrLow != '0)
      |=> (rspValid && rspErr && rspCause == 4'd6 && !memEn)); // R10

  AST_BADOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqAddrLow == '0 && reqOp > 4'd10)
      |=> (rspValid && rspErr && rspCause == 4'd7 && !memEn)); // R11

  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !memEn); // R12

endmodule

bind atomic_mem_unit amu_checker #(.OFF_W(OFF_W)) u_amu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqOp      (reqOp),
  .reqAddrLow (reqAddr[OFF_W-1:0]),
  .rspValid   (rspValid),
  .rspErr     (rspErr),
  .rspCause   (rspCause),
  .memEn      (memEn),
  .memWe      (memWe)
);

// File: tb/atomic_mem_unit_bench.sv
module atomic_mem_unit_bench;

  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int THREADS = 3;
  localparam int TID_W   = 2;
  localparam int WADDR_W = 5;
  localparam int WORDS   = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic [3:0]         reqOp = '0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic [DATA_W-1:0]  reqData = '0;
  logic [TID_W-1:0]   reqTid = '0;
  logic               rspValid;
  logic [DATA_W-1:0]  rspData;
  logic               rspErr;
  logic [3:0]         rspCause;
  logic               memEn, memWe;
  logic [WADDR_W-1:0] memAddr;
  logic [DATA_W-1:0]  memWData;
  logic [DATA_W-1:0]  memRData;
  logic               extWe = 1'b0;
  logic [WADDR_W-1:0] extAddr = '0;
  logic [DATA_W-1:0]  extData = '0;

  logic [DATA_W-1:0] ram [WORDS];

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (extWe) ram[extAddr] <= extData;
    else if (memEn && memWe) ram[memAddr] <= memWData;
    if (memEn && !memWe) memRData <= ram[memAddr];
  end

  atomic_mem_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THREADS(THREADS)) u_atomic_mem_unit (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .reqTid(reqTid),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr), .rspCause(rspCause),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .snoopValid(extWe), .snoopAddr(extAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write a word as another agent (also drives the snoop port)
  task automatic extWrite(input int a, input logic [DATA_W-1:0] v);
    @(negedge clk);
    extWe = 1'b1; extAddr = WADDR_W'(a); extData = v;
    @(negedge clk);
    extWe = 1'b0;
  endtask

  logic [DATA_W-1:0] gData;
  logic              gErr;
  logic [3:0]        gCause;
  int                gLat;
  bit                gMem, gBusyBad, gPulseBad;

  task automatic doReq(input int op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input int tid);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 4'(op); reqAddr = a; reqData = d; reqTid = TID_W'(tid);
    gMem = 0; gBusyBad = 0; gPulseBad = 0; gLat = 0;
    if (!reqReady) gBusyBad = 1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 1; k < 20; k++) begin
      if (memEn) gMem = 1;
      if (rspValid) begin
        gLat = k; gData = rspData; gErr = rspErr; gCause = rspCause;
        break;
      end
      if (reqReady) gBusyBad = 1;
      @(negedge clk);
    end
    @(negedge clk);
    if (rspValid || !reqReady) gPulseBad = 1;
  endtask

  function automatic logic [DATA_W-1:0] expect_rmw(input int op,
      input logic [DATA_W-1:0] o, input logic [DATA_W-1:0] d);
    case (op)
      2: return d;
      3: return o + d;
      4: return o & d;
      5: return o | d;
      6: return o ^ d;
      7: return ($signed(o) > $signed(d)) ? o : d;
      8: return (o > d) ? o : d;
      9: return ($signed(o) < $signed(d)) ? o : d;
      default: return (o < d) ? o : d;
    endcase
  endfunction

  localparam logic [DATA_W-1:0] VALS [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h7fff,
    16'h8000, 16'h8001, 16'hffff, 16'hfffe, 16'h00ff, 16'h1234, 16'hedcb, 16'h5555};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(reqReady), 1);
    check("R1 no rsp in reset", 32'(rspValid), 0);
    check("R1 no mem in reset", 32'(memEn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(reqReady), 1);
    check("R1 no rsp after reset", 32'(rspValid), 0);
    check("R1 no mem after reset", 32'(memEn), 0);

    // R2 / R3: LR then SC succeeds
    extWrite(5, 16'hbeef);
    doReq(0, 6'd10, 0, 0);
    check("R2 lr data", 32'(gData), 32'hbeef);
    check("R2 lr err", 32'(gErr), 0);
    check("R13 lr latency", gLat, 3);
    doReq(1, 6'd10, 16'h1111, 0);
    check("R3 sc result", 32'(gData), 0);
    check("R3 sc mem", 32'(ram[5]), 32'h1111);
    check("R13 sc latency", gLat, 2);
    // R5: second SC fails
    doReq(1, 6'd10, 16'h2222, 0);
    check("R5 repeat sc fails", 32'(gData), 1);
    check("R5 mem unchanged", 32'(ram[5]), 32'h1111);
    // R4: SC without reservation, and wrong word
    doReq(1, 6'd12, 16'h3333, 1);
    check("R4 sc no res", 32'(gData), 1);
    check("R4 mem unchanged", 32'(ram[6]), 0);
    doReq(0, 6'd12, 0, 1);
    doReq(1, 6'd14, 16'h4444, 1);
    check("R4 sc other word", 32'(gData), 1);
    check("R4 other word unchanged", 32'(ram[7]), 0);
    // R6: snoop kills
    doReq(0, 6'd10, 0, 0);
    extWrite(5, 16'h0a0a);
    doReq(1, 6'd10, 16'h5555, 0);
    check("R6 sc after snoop fails", 32'(gData), 1);
    check("R6 snoop data kept", 32'(ram[5]), 32'h0a0a);
    // R6: peer rmw kills, own rmw does not
    doReq(0, 6'd10, 0, 0);
    doReq(3, 6'd10, 16'h0001, 2);
    doReq(1, 6'd10, 16'h6666, 0);
    check("R6 sc after peer write fails", 32'(gData), 1);
    doReq(0, 6'd10, 0, 0);
    doReq(3, 6'd10, 16'h0001, 0);
    doReq(1, 6'd10, 16'h7777, 0);
    check("R6 sc after own write ok", 32'(gData), 0);
    check("R6 own sc mem", 32'(ram[5]), 32'h7777);
    // R7: per-thread reservations
    doReq(0, 6'd20, 0, 1);
    doReq(0, 6'd22, 0, 2);
    doReq(1, 6'd20, 16'h0bad, 0);
    check("R7 other thread has no res", 32'(gData), 1);
    doReq(1, 6'd20, 16'h0c0c, 1);
    check("R7 res survives peer lr", 32'(gData), 0);
    doReq(1, 6'd22, 16'h0d0d, 2);
    check("R7 second thread res", 32'(gData), 0);
    // R10: misaligned
    extWrite(3, 16'h4321);
    doReq(2, 6'd7, 16'hffff, 0);
    check("R10 err", 32'(gErr), 1);
    check("R10 cause", 32'(gCause), 6);
    check("R10 data", 32'(gData), 0);
    check("R10 no mem", 32'(gMem), 0);
    check("R10 mem unchanged", 32'(ram[3]), 32'h4321);
    check("R13 refused latency", gLat, 1);
    doReq(1, 6'd7, 16'hffff, 0);
    check("R10 sc misaligned cause", 32'(gCause), 6);
    // R11: bad opcodes
    for (int op = 11; op < 16; op++) begin
      doReq(op, 6'd6, 16'hffff, 0);
      check("R11 err", 32'(gErr), 1);
      check("R11 cause", 32'(gCause), 7);
      check("R11 no mem", 32'(gMem), 0);
    end
    check("R11 mem unchanged", 32'(ram[3]), 32'h4321);
    // R8 / R9 sweep
    for (int op = 2; op <= 10; op++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          int a;
          a = (i * 12 + j + op) % WORDS;
          extWrite(a, VALS[i]);
          doReq(op, ADDR_W'(a * 2), VALS[j], j % THREADS);
          check((op >= 7) ? "R9 old" : "R8 old", 32'(gData), 32'(VALS[i]));
          check((op >= 7) ? "R9 result" : "R8 result", 32'(ram[a]),
                32'(expect_rmw(op, VALS[i], VALS[j])));
          check("R13 rmw latency", gLat, 4);
          check("R12 busy ready", 32'(gBusyBad), 0);
          check("R12 pulse", 32'(gPulseBad), 0);
        end
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule